// File: doc/BRIEF.md
# UART Register and Command Front End

This block is the byte-wide, memory-mapped control face of a simple UART. A host issues reads and writes on a small register bus. The block decodes them into five kinds of access:

- two mode bytes, reached through a pointer that advances on its own;
- a status byte;
- a packed command byte with three independent fields;
- the receive/transmit data port;
- an interrupt status/mask pair.

It drives one interrupt line from the masked interrupt status.

The serial shifter, the baud generator and the receive FIFO storage all sit outside. A pending transmit byte goes to the serializer over a valid/ready handshake. The external receive FIFO is steered through push, pop and flush strobes, and it reports back its fill level and head byte. The block holds only the single transmit holding byte, the two mode bytes, the mask, and the enable, status and interrupt flags. Status, interrupt status and the interrupt line are registered, and each changes one clock after the access or event that causes it.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status byte reads 0x08 (transmitter empty only). Both mode bytes, the interrupt status and the mask read 0. Receiver and transmitter are disabled, so `rxReady`=0 and `txValid`=0, and `irq`=0.
- R2: Only address bits 5:0 are decoded.
  - Reads: 0x00 gives the mode byte, 0x04 the status, 0x0C receive data, 0x14 the interrupt status, 0x18 the high byte of `BAUD_DIV` and 0x1C its low byte. Every other offset reads 0.
  - Writes to 0x04 change nothing.
- R3: Offset 0x00 reaches mode byte 1 or mode byte 2 through a pointer that starts at mode byte 1. A write stores into the selected byte and then points to mode byte 2. A read does not move the pointer.
- R4: Command bits 6:4 form the miscellaneous field.
  - 1 points the mode pointer back to mode byte 1.
  - 2 disables the receiver, flushes the FIFO and clears status bits 0 and 1.
  - 3 disables the transmitter, drops any pending byte (status bit 3 set) and clears status bit 2.
  - 5 clears the break flag.
  - 0, 4, 6 and 7 do nothing.
- R5: Command bits 3:2 act on the transmitter and bits 1:0 on the receiver: 1 enables, 2 disables, and 0 or 3 leave the state alone. The fields act in the order miscellaneous, then transmitter, then receiver, so an enable in the same byte overrides a reset from the miscellaneous field. Status bit 2 equals the transmitter enable. `rxReady` is high when the receiver is enabled and the FIFO is not full.
- R6: A write to offset 0x0C latches the byte and clears status bit 3. While the transmitter is enabled and status bit 3 is 0, `txValid` is high with the byte on `txData`, held steady until `txReady`. The accepting cycle sets status bit 3. A byte written while the transmitter is disabled waits for an enable.
- R7: Status bit 0 is set when the FIFO level is nonzero, and bit 1 when it equals `FIFO_DEPTH`; bits 7:4 read 0. A read of offset 0x0C returns the FIFO head and pops it. With an empty FIFO that read returns 0 and pops nothing. `fifoPush` follows `rxValid` only while `rxReady` is high.
- R8: Interrupt status bit 0 equals status bit 2. Bit 1 equals status bit 1 when bit 6 of mode byte 1 is set, and status bit 0 otherwise.
- R9: Interrupt status bit 2 is set by a `brkEvent` pulse and stays set until a command with miscellaneous field 5.
- R10: `irq` is high exactly when the interrupt status ANDed with the mask written at offset 0x14 is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register |
| txValid | output | 1 | Pending transmit byte offered to the serializer |
| txData | output | 8 | Transmit holding byte |
| txReady | input | 1 | Serializer accepts the offered byte |
| rxValid | input | 1 | Receiver has a byte for the FIFO |
| rxReady | output | 1 | Receiver enabled and FIFO not full |
| fifoPush | output | 1 | Write the receiver byte into the FIFO |
| fifoPop | output | 1 | Drop the FIFO head |
| fifoFlush | output | 1 | Empty the FIFO |
| fifoLevel | input | LVL_W | FIFO fill level |
| fifoHead | input | 8 | Oldest FIFO byte |
| brkEvent | input | 1 | Break condition detected by the receiver |
| irq | output | 1 | Interrupt request |

## Verification
The command decoder is swept over every value of each field, and each value is applied on top of both enable states.

- The miscellaneous sweep runs against a loaded state: FIFO partly filled, a transmit byte pending, the break flag set and the pointer on mode byte 2. A wrong clear or a missing one shows up in the status, the interrupt status or the mode read.
- The transmitter/receiver sweep covers all sixteen pairs from all four prior states, which separates enable, disable, no-op and reserved.
- All 256 addresses are read after reset to show the aliasing of the upper bits and the zero default.
- The mask is swept over all eight low-bit values under two interrupt-status patterns. This shows that `irq` depends only on the overlap of the two.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  // Register offsets within the decoded window
  localparam logic [5:0] OFF_MODE = 6'h00;
  localparam logic [5:0] OFF_STAT = 6'h04;
  localparam logic [5:0] OFF_CMD  = 6'h08;
  localparam logic [5:0] OFF_DATA = 6'h0C;
  localparam logic [5:0] OFF_INT  = 6'h14;
  localparam logic [5:0] OFF_DIVH = 6'h18;
  localparam logic [5:0] OFF_DIVL = 6'h1C;

  typedef enum logic [2:0] {
    MISC_NOP    = 3'd0,
    MISC_PTRRST = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_ERRRST = 3'd4,
    MISC_BRKCLR = 3'd5,
    MISC_BRKON  = 3'd6,
    MISC_BRKOFF = 3'd7
  } miscOp_t;

  // Strobes from control to datapath, one access per cycle
  typedef struct packed {
    logic wrMode;
    logic wrTx;
    logic wrMask;
    logic ptrReset;
    logic rxReset;
    logic txReset;
    logic brkClr;
    logic txOn;
    logic txOff;
    logic rxOn;
    logic rxOff;
    logic popRx;
  } feStrobe_t;

endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [6:0]        cmdBits,
  input  logic [LVL_W-1:0]  fifoLevel,
  output feStrobe_t         strobe,
  output logic [5:0]        offset
);

  localparam int OFF_W = 6;

  logic    unusedAddrHi;
  logic    cmdWr;
  miscOp_t miscOp;

  generate
    if (ADDR_W > OFF_W) begin : g_hi
      assign unusedAddrHi = ^busAddr[ADDR_W-1:OFF_W];
    end else begin : g_nohi
      assign unusedAddrHi = 1'b0;
    end
  endgenerate

  assign offset = busAddr[OFF_W-1:0];
  assign cmdWr  = busWr && (offset == OFF_CMD);
  assign miscOp = miscOp_t'(cmdBits[6:4]);

  always_comb begin
    strobe        = '0;
    strobe.wrMode = busWr && (offset == OFF_MODE);
    strobe.wrTx   = busWr && (offset == OFF_DATA);
    strobe.wrMask = busWr && (offset == OFF_INT);
    strobe.popRx  = busRd && (offset == OFF_DATA) && (fifoLevel != '0);
    if (cmdWr) begin
      case (miscOp)
        MISC_PTRRST: strobe.ptrReset = 1'b1;
        MISC_RXRST:  strobe.rxReset  = 1'b1;
        MISC_TXRST:  strobe.txReset  = 1'b1;
        MISC_BRKCLR: strobe.brkClr   = 1'b1;
        default: ;
      endcase
      strobe.txOn  = (cmdBits[3:2] == 2'd1);
      strobe.txOff = (cmdBits[3:2] == 2'd2);
      strobe.rxOn  = (cmdBits[1:0] == 2'd1);
      strobe.rxOff = (cmdBits[1:0] == 2'd2);
    end
  end

endmodule

// File: rtl/uart_fe_dp.sv
module uart_fe_dp
  import uart_fe_pkg::*;
#(
  parameter int          FIFO_DEPTH = 4,
  parameter int          LVL_W      = 3,
  parameter logic [15:0] BAUD_DIV   = 16'h0010
) (
  input  logic             clk,
  input  logic             rstN,
  input  feStrobe_t        strobe,
  input  logic [5:0]       offset,
  input  logic [7:0]       busWrData,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [7:0]       fifoHead,
  input  logic             txReady,
  input  logic             brkEvent,
  output logic [7:0]       busRdData,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             rxReady,
  output logic             irq,
  output logic [7:0]       statusByte,
  output logic [7:0]       isrByte,
  output logic [7:0]       imrByte,
  output logic             modePtr
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [7:0] mode1Q, mode2Q, imrQ, txHoldQ, isrQ;
  logic       modePtrQ, rxEnQ, txEnQ, txEmptyQ, stRdyQ, stFullQ, irqQ;
  logic       txEnN, rxEnN, txEmptyN, stRdyN, stFullN, brkN, rxSelFull, irqN;
  logic [7:0] imrN, isrN;
  logic       txFire;

  assign txValid = txEnQ && !txEmptyQ;
  assign txFire  = txValid && txReady;

  always_comb begin
    // field order: miscellaneous, transmitter, receiver
    txEnN = txEnQ;
    if (strobe.txReset) txEnN = 1'b0;
    if (strobe.txOn)    txEnN = 1'b1;
    if (strobe.txOff)   txEnN = 1'b0;

    rxEnN = rxEnQ;
    if (strobe.rxReset) rxEnN = 1'b0;
    if (strobe.rxOn)    rxEnN = 1'b1;
    if (strobe.rxOff)   rxEnN = 1'b0;

    txEmptyN = txEmptyQ;
    if (txFire)         txEmptyN = 1'b1;
    if (strobe.wrTx)    txEmptyN = 1'b0;
    if (strobe.txReset) txEmptyN = 1'b1;

    stRdyN  = !strobe.rxReset && (fifoLevel != '0);
    stFullN = !strobe.rxReset && (fifoLevel == FULL_LVL);
    brkN    = brkEvent || (isrQ[2] && !strobe.brkClr);
    imrN    = strobe.wrMask ? busWrData : imrQ;

    rxSelFull = (strobe.wrMode && !modePtrQ) ? busWrData[6] : mode1Q[6];
    isrN      = {5'b0, brkN, (rxSelFull ? stFullN : stRdyN), txEnN};
    irqN      = |(isrN & imrN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode1Q   <= '0;
      mode2Q   <= '0;
      modePtrQ <= 1'b0;
      imrQ     <= '0;
      isrQ     <= '0;
      txHoldQ  <= '0;
      rxEnQ    <= 1'b0;
      txEnQ    <= 1'b0;
      txEmptyQ <= 1'b1;
      stRdyQ   <= 1'b0;
      stFullQ  <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      if (strobe.wrMode) begin
        if (modePtrQ) mode2Q <= busWrData;
        else          mode1Q <= busWrData;
      end
      if (strobe.ptrReset)    modePtrQ <= 1'b0;
      else if (strobe.wrMode) modePtrQ <= 1'b1;
      if (strobe.wrTx) txHoldQ <= busWrData;
      imrQ     <= imrN;
      isrQ     <= isrN;
      rxEnQ    <= rxEnN;
      txEnQ    <= txEnN;
      txEmptyQ <= txEmptyN;
      stRdyQ   <= stRdyN;
      stFullQ  <= stFullN;
      irqQ     <= irqN;
    end
  end

  assign statusByte = {4'b0, txEmptyQ, txEnQ, stFullQ, stRdyQ};
  assign isrByte    = isrQ;
  assign imrByte    = imrQ;
  assign modePtr    = modePtrQ;
  assign txData     = txHoldQ;
  assign rxReady    = rxEnQ && (fifoLevel != FULL_LVL);
  assign irq        = irqQ;

  always_comb begin
    case (offset)
      OFF_MODE: busRdData = modePtrQ ? mode2Q : mode1Q;
      OFF_STAT: busRdData = statusByte;
      OFF_DATA: busRdData = (fifoLevel != '0) ? fifoHead : 8'h00;
      OFF_INT:  busRdData = isrQ;
      OFF_DIVH: busRdData = BAUD_DIV[15:8];
      OFF_DIVL: busRdData = BAUD_DIV[7:0];
      default:  busRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_fe_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] BAUD_DIV   = 16'h0010,
  parameter int          LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              rxValid,
  output logic              rxReady,
  output logic              fifoPush,
  output logic              fifoPop,
  output logic              fifoFlush,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic [7:0]        fifoHead,
  input  logic              brkEvent,
  output logic              irq
);

  feStrobe_t  strobe;
  logic [5:0] offset;
  logic [7:0] statusByte, isrByte, imrByte;
  logic       modePtr;

  uart_fe_ctrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .cmdBits(busWrData[6:0]), .fifoLevel(fifoLevel),
    .strobe(strobe), .offset(offset)
  );

  uart_fe_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .BAUD_DIV(BAUD_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .offset(offset),
    .busWrData(busWrData), .fifoLevel(fifoLevel), .fifoHead(fifoHead),
    .txReady(txReady), .brkEvent(brkEvent), .busRdData(busRdData),
    .txValid(txValid), .txData(txData), .rxReady(rxReady), .irq(irq),
    .statusByte(statusByte), .isrByte(isrByte), .imrByte(imrByte),
    .modePtr(modePtr)
  );

  assign fifoPush  = rxValid && rxReady;
  assign fifoPop   = strobe.popRx;
  assign fifoFlush = strobe.rxReset;

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              txValid,
  input logic [7:0]        txData,
  input logic              txReady,
  input logic              fifoPush,
  input logic              fifoPop,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              irq,
  input logic [7:0]        statusByte,
  input logic [7:0]        isrByte,
  input logic [7:0]        imrByte,
  input logic              modePtr
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusByte == 8'h08) && (isrByte == 8'h00) && (imrByte == 8'h00) && !irq);

  // R3
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr[5:0] == 6'h00)) |=> modePtr);

  // R6
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !statusByte[3]);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !busWr) |=> txValid && $stable(txData));

  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoLevel != '0));

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> (fifoLevel != LVL_W'(FIFO_DEPTH)));

  // R8
  isr_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    isrByte[0] == statusByte[2]);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(isrByte & imrByte));

endmodule

bind uart_regfront uart_regfront_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .txValid(txValid), .txData(txData), .txReady(txReady),
  .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoLevel(fifoLevel),
  .irq(irq), .statusByte(statusByte), .isrByte(isrByte),
  .imrByte(imrByte), .modePtr(modePtr)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

  localparam logic [15:0] DIV = 16'h1234;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       txValid, rxReady, fifoPush, fifoPop, fifoFlush, irq;
  logic [7:0] txData;
  logic       txReady = 1'b1, rxValid = 1'b0, brkEvent = 1'b0;
  logic [2:0] fifoLevel;
  logic [7:0] fifoHead;
  logic [7:0] pushByte = '0;
  logic [7:0] fmem [4];
  int         flvl;
  int         nTests = 0, nFail = 0;

  always #2.5 clk = ~clk;

  uart_regfront #(.ADDR_W(8), .FIFO_DEPTH(4), .BAUD_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxReady(rxReady),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoFlush(fifoFlush),
    .fifoLevel(fifoLevel), .fifoHead(fifoHead), .brkEvent(brkEvent), .irq(irq)
  );

  // Behavioural receive FIFO, four entries
  assign fifoLevel = 3'(flvl);
  assign fifoHead  = fmem[0];
  always @(posedge clk) begin : fifo_model
    logic [7:0] m [4];
    int l;
    m = fmem;
    l = flvl;
    if (!rstN || fifoFlush) l = 0;
    else begin
      if (fifoPop && l > 0) begin
        for (int i = 0; i < 3; i++) m[i] = m[i + 1];
        l--;
      end
      if (fifoPush && l < 4) begin
        m[l] = pushByte;
        l++;
      end
    end
    fmem <= m;
    flvl <= l;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRead(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 chk(tag, busRdData, exp);
    @(negedge clk); busRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pushRx(logic [7:0] b);
    @(negedge clk); pushByte = b; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseBrk();
    @(negedge clk); brkEvent = 1'b1;
    @(negedge clk); brkEvent = 1'b0;
    @(negedge clk);
  endtask

  task automatic cleanUp();
    busWrite(8'h08, 8'h3A);
    busWrite(8'h08, 8'h2A);
    busWrite(8'h08, 8'h50);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    logic [7:0] exp;
    logic [7:0] isrNow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 txValid", {7'b0, txValid}, 8'h00);
    chk("R1 rxReady", {7'b0, rxReady}, 8'h00);

    // R2 / R1 read sweep over every address
    for (int a = 0; a < 256; a++) begin
      case (a & 63)
        8'h04:   exp = 8'h08;
        8'h18:   exp = DIV[15:8];
        8'h1C:   exp = DIV[7:0];
        default: exp = 8'h00;
      endcase
      busRead(8'(a), exp, "R2 R1 reset read sweep");
    end

    // R2 status write ignored
    busWrite(8'h04, 8'hFF);
    busRead(8'h04, 8'h08, "R2 status write ignored");

    // R3 mode pointer
    busWrite(8'h00, 8'hA1);
    busRead(8'h00, 8'h00, "R3 pointer moved to mode 2");
    busWrite(8'h00, 8'hB2);
    busRead(8'h00, 8'hB2, "R3 mode 2 written");
    busRead(8'h00, 8'hB2, "R3 read keeps pointer");
    busWrite(8'h00, 8'hC3);
    busRead(8'h00, 8'hC3, "R3 pointer stays on mode 2");
    busWrite(8'h08, 8'h10);
    busRead(8'h00, 8'hA1, "R4 R3 pointer reset to mode 1");
    busWrite(8'h40, 8'h05);
    busWrite(8'h08, 8'h10);
    busRead(8'h80, 8'h05, "R2 upper address bits aliased");

    // R5 transmitter/receiver field sweep from every prior state
    for (int pt = 0; pt < 2; pt++)
      for (int pr = 0; pr < 2; pr++)
        for (int tc = 0; tc < 4; tc++)
          for (int rc = 0; rc < 4; rc++) begin
            logic expTx, expRx;
            busWrite(8'h08, 8'(((pt != 0 ? 1 : 2) << 2) | (pr != 0 ? 1 : 2)));
            busWrite(8'h08, 8'((tc << 2) | rc));
            expTx = (tc == 1) ? 1'b1 : (tc == 2) ? 1'b0 : 1'(pt);
            expRx = (rc == 1) ? 1'b1 : (rc == 2) ? 1'b0 : 1'(pr);
            busRead(8'h04, {4'b0, 1'b1, expTx, 2'b00}, "R5 transmitter field");
            chk("R5 receiver field", {7'b0, rxReady}, {7'b0, expRx});
          end
    // R5 enable in the same byte overrides a miscellaneous reset
    busWrite(8'h08, 8'h35);
    busRead(8'h04, 8'h0C, "R5 field order tx");
    busWrite(8'h08, 8'h21);
    chk("R5 field order rx", {7'b0, rxReady}, 8'h01);
    busWrite(8'h08, 8'h0A);

    // R4 miscellaneous field sweep against a loaded state
    for (int m = 0; m < 8; m++) begin
      cleanUp();
      busWrite(8'h08, 8'h10);
      busWrite(8'h00, 8'h40);
      busWrite(8'h00, 8'h22);
      busWrite(8'h08, 8'h05);
      pushRx(8'h11);
      pushRx(8'h22);
      pulseBrk();
      txReady = 1'b0;
      busWrite(8'h0C, 8'h77);
      busWrite(8'h08, 8'(m << 4));
      exp = (m == 2) ? 8'h04 : (m == 3) ? 8'h09 : 8'h05;
      busRead(8'h04, exp, "R4 status after misc command");
      exp = ((m == 3) ? 8'h00 : 8'h01) | ((m == 5) ? 8'h00 : 8'h04);
      busRead(8'h14, exp, "R4 R9 interrupt status after misc command");
      busRead(8'h00, (m == 1) ? 8'h40 : 8'h22, "R4 pointer after misc command");
      chk("R4 receiver after misc command", {7'b0, rxReady}, (m == 2) ? 8'h00 : 8'h01);
      chk("R4 tx offer after misc command", {7'b0, txValid}, (m == 3) ? 8'h00 : 8'h01);
      txReady = 1'b1;
    end
    cleanUp();

    // R8 receive interrupt source selection
    busWrite(8'h08, 8'h10);
    busWrite(8'h00, 8'h00);
    busWrite(8'h08, 8'h01);
    busRead(8'h14, 8'h00, "R8 idle interrupt status");
    pushRx(8'h31);
    busRead(8'h14, 8'h02, "R8 ready selected");
    busWrite(8'h08, 8'h10);
    busWrite(8'h00, 8'h40);
    busRead(8'h14, 8'h00, "R8 full selected, not full");
    pushRx(8'h32);
    pushRx(8'h33);
    pushRx(8'h34);
    busRead(8'h14, 8'h02, "R8 full selected, full");
    busRead(8'h04, 8'h0B, "R7 status full");
    chk("R7 rxReady low when full", {7'b0, rxReady}, 8'h00);
    pushRx(8'h99);

    // R10 mask sweep under two interrupt patterns
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) pulseBrk();
      isrNow = (pass == 1) ? 8'h06 : 8'h02;
      for (int im = 0; im < 8; im++) begin
        busWrite(8'h14, 8'(im));
        chk("R10 irq from mask", {7'b0, irq}, {7'b0, |(isrNow & 8'(im))});
      end
    end
    busWrite(8'h14, 8'h00);

    // R7 pops in order, empty read returns zero
    busRead(8'h0C, 8'h31, "R7 pop 1");
    busRead(8'h0C, 8'h32, "R7 pop 2");
    busRead(8'h0C, 8'h33, "R7 pop 3");
    busRead(8'h0C, 8'h34, "R7 pop 4, push while full dropped");
    busRead(8'h0C, 8'h00, "R7 empty read");
    busRead(8'h04, 8'h08, "R7 status empty");

    // R9 sticky break flag
    busRead(8'h14, 8'h04, "R9 break flag sticky");
    busWrite(8'h08, 8'h40);
    busRead(8'h14, 8'h04, "R9 misc 4 keeps flag");
    busWrite(8'h08, 8'h50);
    busRead(8'h14, 8'h00, "R9 misc 5 clears flag");

    // R6 transmit handshake
    busWrite(8'h08, 8'h04);
    txReady = 1'b0;
    busWrite(8'h0C, 8'h5A);
    chk("R6 offer valid", {7'b0, txValid}, 8'h01);
    chk("R6 offer data", txData, 8'h5A);
    busRead(8'h04, 8'h04, "R6 empty cleared");
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    chk("R6 accepted", {7'b0, txValid}, 8'h00);
    busRead(8'h04, 8'h0C, "R6 empty set on accept");
    busWrite(8'h08, 8'h08);
    busWrite(8'h0C, 8'hA5);
    chk("R6 held while disabled", {7'b0, txValid}, 8'h00);
    busRead(8'h04, 8'h00, "R6 disabled pending status");
    busWrite(8'h08, 8'h04);
    chk("R6 offered after enable", {7'b0, txValid}, 8'h01);
    chk("R6 offered data after enable", txData, 8'hA5);
    txReady = 1'b1;
    @(negedge clk);
    busRead(8'h04, 8'h0C, "R6 final status");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule